// File: doc/BRIEF.md
# Cache Array Access Port

This block lets software read and write the tag and data arrays of an instruction cache and an operand cache as plain 32-bit words. An access arrives with an address, a size code, a write flag and write data. The top byte of the address picks one of four arrays. The lower address bits pick the line and, for data arrays, the word within the line. The block does not hold the arrays. It drives a shared line index, a word select and per-array write enables, and it reads each array's current entry back.

Tag writes come in two modes, selected by address bit 3. A direct write replaces the tag and the status bits. An associative write first compares the tag carried in the write data with the stored tag, and changes the status only on a match. Some operand-cache tag writes would drop a modified line. For those, the block raises a writeback request with the line index and holds the access until the cache acknowledges it. Only then does it commit the new tag entry, so the old contents are written out under the old tag.

Top module: `cache_array_port`

## Requirements
- R1: Address bits [31:24] select the target: 0xF0 is the instruction tag array, 0xF1 the instruction data array, 0xF4 the operand tag array and 0xF5 the operand data array. Any other value reads as 0, and a write to it changes no array.
- R2: Only `acc_size` code 2 (32-bit) takes effect. With any other code a read returns 0, and a write changes no array and raises no writeback.
- R3: The operand line index is address bits [13:5] and the instruction line index is address bits [12:5], so bit 13 is ignored for the instruction cache. The data word within a line is address bits [4:2].
- R4: An operand tag read returns valid in bit 0, dirty in bit 1 and the 19-bit tag in bits [28:10], with all other bits 0. An instruction tag read has the same layout with bit 1 always 0.
- R5: On a direct operand tag write (address bit 3 = 0), the new entry takes its tag from data bits [28:10], valid from data bit 0 and dirty from data bit 1. If the old line is valid and dirty, a writeback of that index is requested first, and the old entry stays in place until `wb_ack`.
- R6: A direct instruction tag write loads the tag from data bits [28:10] and valid from data bit 0.
- R7: An associative tag write (address bit 3 = 1) to an invalid line, or one whose stored tag differs from data bits [28:10], changes nothing and raises no writeback.
- R8: On an associative operand hit, a writeback is requested when data bits [1:0] are nonzero and the line is dirty. Valid and dirty are then taken from data bits 0 and 1, and the tag is kept.
- R9: On an associative instruction hit, only valid changes, taken from data bit 0.
- R10: A data array read returns the addressed 32-bit word. A data array write stores `acc_wdata` into that word.
- R11: A request is taken in a cycle where `acc_valid` and `acc_ready` are both high. `acc_done` pulses for one cycle when the access completes, with `acc_rdata` valid (0 for writes). While `wb_req` waits for `wb_ack`, the request and `wb_idx` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Block idle, request may be taken |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 32 | Read result, valid with acc_done |
| arr_idx | output | 9 | Line index to the arrays (the instruction cache uses the low 8 bits) |
| arr_word | output | 3 | Word within the line for the data arrays |
| ic_tag_rd | input | 20 | Instruction tag entry {valid, tag} at arr_idx |
| oc_tag_rd | input | 21 | Operand tag entry {dirty, valid, tag} at arr_idx |
| ic_dat_rd | input | 32 | Instruction data word at arr_idx/arr_word |
| oc_dat_rd | input | 32 | Operand data word at arr_idx/arr_word |
| tag_wd | output | 21 | New tag entry {dirty, valid, tag} (the instruction array takes the low 20 bits) |
| dat_wd | output | 32 | New data word |
| ic_tag_we | output | 1 | Write the instruction tag entry |
| oc_tag_we | output | 1 | Write the operand tag entry |
| ic_dat_we | output | 1 | Write the instruction data word |
| oc_dat_we | output | 1 | Write the operand data word |
| wb_req | output | 1 | Writeback of the operand line at wb_idx requested |
| wb_idx | output | 9 | Operand line to write back |
| wb_ack | input | 1 | Cache has finished the writeback |

## Verification
Some properties are checked on every cycle. At most one array write enable is active at a time. No operand tag write lands while a writeback is outstanding, and no other array is written during it. `wb_req` and `wb_idx` hold until acknowledged. A taken request leaves the block busy in the next cycle. `acc_done` never lasts two cycles. The bench scenarios are the only way to show the values themselves: the read formats, the index and word bit selection, the choice between direct and associative updates, the hit and miss outcomes, and that an ignored size or window leaves the arrays untouched. It also shows that the entry seen at the moment of acknowledge is still the old one.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 19;
  localparam int TAG_LSB  = 10;
  localparam int ENT_W    = TAG_W + 2;
  localparam int IC_ENT_W = TAG_W + 1;

  localparam logic [7:0] WIN_IC_TAG = 8'hF0;
  localparam logic [7:0] WIN_IC_DAT = 8'hF1;
  localparam logic [7:0] WIN_OC_TAG = 8'hF4;
  localparam logic [7:0] WIN_OC_DAT = 8'hF5;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_IC_TAG,
    TGT_IC_DAT,
    TGT_OC_TAG,
    TGT_OC_DAT
  } tgt_e;

  typedef struct packed {
    logic             dirty;
    logic             valid;
    logic [TAG_W-1:0] tag;
  } tag_ent_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_WBWAIT
  } cap_state_e;
endpackage

// File: rtl/cap_decode.sv
module cap_decode
  import cap_pkg::*;
#(
  parameter int OC_IW  = 9,
  parameter int IC_IW  = 8,
  parameter int WORD_W = 3
) (
  input  logic [31:0]       addr,
  input  logic [1:0]        size,
  output tgt_e              tgt,
  output logic              size_ok,
  output logic              assoc,
  output logic              is_oc,
  output logic [OC_IW-1:0]  oc_idx,
  output logic [IC_IW-1:0]  ic_idx,
  output logic [WORD_W-1:0] word
);
  localparam int IDX_LSB = WORD_W + 2;

  logic unused_addr;
  assign unused_addr = ^addr;

  always_comb begin
    case (addr[31:24])
      WIN_IC_TAG: tgt = TGT_IC_TAG;
      WIN_IC_DAT: tgt = TGT_IC_DAT;
      WIN_OC_TAG: tgt = TGT_OC_TAG;
      WIN_OC_DAT: tgt = TGT_OC_DAT;
      default:    tgt = TGT_NONE;
    endcase
  end

  assign size_ok = (size == SIZE_WORD);
  assign assoc   = addr[3];
  assign is_oc   = (tgt == TGT_OC_TAG) || (tgt == TGT_OC_DAT);
  assign oc_idx  = addr[IDX_LSB +: OC_IW];
  assign ic_idx  = addr[IDX_LSB +: IC_IW];
  assign word    = addr[2 +: WORD_W];
endmodule

// File: rtl/cap_tag_update.sv
module cap_tag_update
  import cap_pkg::*;
(
  input  logic              is_oc,
  input  logic              assoc,
  input  logic [DATA_W-1:0] wdata,
  input  tag_ent_t          cur,
  output logic              commit,
  output logic              need_wb,
  output tag_ent_t          nxt
);
  logic [TAG_W-1:0] wtag;
  logic             hit;
  logic             unused_wdata;

  assign wtag         = wdata[TAG_LSB +: TAG_W];
  assign hit          = cur.valid && (cur.tag == wtag);
  assign unused_wdata = ^wdata;

  always_comb begin
    commit  = 1'b0;
    need_wb = 1'b0;
    nxt     = cur;
    if (!assoc) begin
      commit    = 1'b1;
      nxt.tag   = wtag;
      nxt.valid = wdata[0];
      nxt.dirty = is_oc ? wdata[1] : 1'b0;
      need_wb   = is_oc && cur.valid && cur.dirty;
    end else if (hit) begin
      commit    = 1'b1;
      nxt.tag   = cur.tag;
      nxt.valid = wdata[0];
      nxt.dirty = is_oc ? wdata[1] : 1'b0;
      need_wb   = is_oc && cur.dirty && (wdata[1:0] != 2'b00);
    end
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  output logic              acc_done,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              req_write,
  input  logic              req_legal,
  input  logic              req_is_tag,
  input  logic [DATA_W-1:0] rd_value,
  input  logic              need_wb,
  input  logic              commit,
  input  logic              wb_ack,
  output logic              wb_req,
  output logic              tag_we,
  output logic              dat_we,
  output logic              latch_en
);
  cap_state_e        state_q, state_d;
  logic              finish;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    state_d  = state_q;
    tag_we   = 1'b0;
    dat_we   = 1'b0;
    wb_req   = 1'b0;
    finish   = 1'b0;
    latch_en = 1'b0;
    rdata_d  = req_write ? '0 : rd_value;
    case (state_q)
      ST_IDLE: begin
        if (acc_valid) begin
          latch_en = 1'b1;
          state_d  = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (req_write && req_legal && req_is_tag && need_wb) begin
          state_d = ST_WBWAIT;
        end else begin
          finish  = 1'b1;
          state_d = ST_IDLE;
          if (req_write && req_legal) begin
            if (req_is_tag) tag_we = commit;
            else            dat_we = 1'b1;
          end
        end
      end
      ST_WBWAIT: begin
        wb_req = 1'b1;
        if (wb_ack) begin
          tag_we  = commit;
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (finish) rdata_q <= rdata_d;
    end
  end

  assign acc_ready = (state_q == ST_IDLE);
  assign acc_done  = done_q;
  assign acc_rdata = rdata_q;
endmodule

// File: rtl/cache_array_port.sv
module cache_array_port
  import cap_pkg::*;
#(
  parameter int OC_LINES   = 512,
  parameter int IC_LINES   = 256,
  parameter int LINE_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic                          acc_write,
  input  logic [1:0]                    acc_size,
  input  logic [31:0]                   acc_addr,
  input  logic [DATA_W-1:0]             acc_wdata,
  output logic                          acc_ready,
  output logic                          acc_done,
  output logic [DATA_W-1:0]             acc_rdata,
  output logic [$clog2(OC_LINES)-1:0]   arr_idx,
  output logic [$clog2(LINE_WORDS)-1:0] arr_word,
  input  logic [IC_ENT_W-1:0]           ic_tag_rd,
  input  logic [ENT_W-1:0]              oc_tag_rd,
  input  logic [DATA_W-1:0]             ic_dat_rd,
  input  logic [DATA_W-1:0]             oc_dat_rd,
  output logic [ENT_W-1:0]              tag_wd,
  output logic [DATA_W-1:0]             dat_wd,
  output logic                          ic_tag_we,
  output logic                          oc_tag_we,
  output logic                          ic_dat_we,
  output logic                          oc_dat_we,
  output logic                          wb_req,
  output logic [$clog2(OC_LINES)-1:0]   wb_idx,
  input  logic                          wb_ack
);
  localparam int OC_IW  = $clog2(OC_LINES);
  localparam int IC_IW  = $clog2(IC_LINES);
  localparam int WORD_W = $clog2(LINE_WORDS);

  // Request held for the duration of the access
  logic [31:0]       addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic [1:0]        size_q;
  logic              latch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
    end else if (latch_en) begin
      addr_q  <= acc_addr;
      wdata_q <= acc_wdata;
      write_q <= acc_write;
      size_q  <= acc_size;
    end
  end

  tgt_e              tgt;
  logic              size_ok, assoc, is_oc;
  logic [OC_IW-1:0]  oc_idx;
  logic [IC_IW-1:0]  ic_idx;
  logic [WORD_W-1:0] word;

  cap_decode #(.OC_IW(OC_IW), .IC_IW(IC_IW), .WORD_W(WORD_W)) u_dec (
    .addr    (addr_q),
    .size    (size_q),
    .tgt     (tgt),
    .size_ok (size_ok),
    .assoc   (assoc),
    .is_oc   (is_oc),
    .oc_idx  (oc_idx),
    .ic_idx  (ic_idx),
    .word    (word)
  );

  assign arr_idx  = is_oc ? oc_idx : OC_IW'(ic_idx);
  assign arr_word = word;
  assign wb_idx   = arr_idx;

  tag_ent_t cur_ent, nxt_ent;
  logic     commit, need_wb;

  assign cur_ent = is_oc ? tag_ent_t'(oc_tag_rd) : tag_ent_t'({1'b0, ic_tag_rd});

  cap_tag_update u_tag (
    .is_oc   (is_oc),
    .assoc   (assoc),
    .wdata   (wdata_q),
    .cur     (cur_ent),
    .commit  (commit),
    .need_wb (need_wb),
    .nxt     (nxt_ent)
  );

  // Read formatting: tag in [28:10], dirty in bit 1, valid in bit 0
  logic [DATA_W-1:0] rd_value;
  always_comb begin
    rd_value = '0;
    if (size_ok) begin
      case (tgt)
        TGT_IC_TAG, TGT_OC_TAG: begin
          rd_value[TAG_LSB +: TAG_W] = cur_ent.tag;
          rd_value[1]                = cur_ent.dirty;
          rd_value[0]                = cur_ent.valid;
        end
        TGT_IC_DAT: rd_value = ic_dat_rd;
        TGT_OC_DAT: rd_value = oc_dat_rd;
        default:    rd_value = '0;
      endcase
    end
  end

  logic req_legal, req_is_tag, tag_we, dat_we;
  assign req_legal  = size_ok && (tgt != TGT_NONE);
  assign req_is_tag = (tgt == TGT_IC_TAG) || (tgt == TGT_OC_TAG);

  cap_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_done   (acc_done),
    .acc_rdata  (acc_rdata),
    .req_write  (write_q),
    .req_legal  (req_legal),
    .req_is_tag (req_is_tag),
    .rd_value   (rd_value),
    .need_wb    (need_wb),
    .commit     (commit),
    .wb_ack     (wb_ack),
    .wb_req     (wb_req),
    .tag_we     (tag_we),
    .dat_we     (dat_we),
    .latch_en   (latch_en)
  );

  assign tag_wd    = nxt_ent;
  assign dat_wd    = wdata_q;
  assign ic_tag_we = tag_we && (tgt == TGT_IC_TAG);
  assign oc_tag_we = tag_we && (tgt == TGT_OC_TAG);
  assign ic_dat_we = dat_we && (tgt == TGT_IC_DAT);
  assign oc_dat_we = dat_we && (tgt == TGT_OC_DAT);
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int OC_IW = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             acc_done,
  input logic             ic_tag_we,
  input logic             oc_tag_we,
  input logic             ic_dat_we,
  input logic             oc_dat_we,
  input logic             wb_req,
  input logic             wb_ack,
  input logic [OC_IW-1:0] wb_idx
);
  assert_one_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ic_tag_we, oc_tag_we, ic_dat_we, oc_dat_we}));

  assert_no_early_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |-> !oc_tag_we);

  assert_wb_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (!ic_tag_we && !ic_dat_we && !oc_dat_we && !acc_ready));

  assert_wb_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> (!acc_ready && !acc_done));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);
endmodule

bind cache_array_port cap_checker #(.OC_IW(OC_IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_done  (acc_done),
  .ic_tag_we (ic_tag_we),
  .oc_tag_we (oc_tag_we),
  .ic_dat_we (ic_dat_we),
  .oc_dat_we (oc_dat_we),
  .wb_req    (wb_req),
  .wb_ack    (wb_ack),
  .wb_idx    (wb_idx)
);

// File: tb/sim_cache_array_port.sv
module sim_cache_array_port;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_size;
  logic [31:0] acc_addr, acc_wdata;
  logic        acc_ready, acc_done;
  logic [31:0] acc_rdata;
  logic [8:0]  arr_idx;
  logic [2:0]  arr_word;
  logic [19:0] ic_tag_rd;
  logic [20:0] oc_tag_rd;
  logic [31:0] ic_dat_rd, oc_dat_rd;
  logic [20:0] tag_wd;
  logic [31:0] dat_wd;
  logic        ic_tag_we, oc_tag_we, ic_dat_we, oc_dat_we;
  logic        wb_req, wb_ack;
  logic [8:0]  wb_idx;

  int checks = 0;
  int errors = 0;

  // Array models
  logic [19:0] ic_tag_m [256];
  logic [20:0] oc_tag_m [512];
  logic [31:0] ic_dat_m [2048];
  logic [31:0] oc_dat_m [4096];

  assign ic_tag_rd = ic_tag_m[arr_idx[7:0]];
  assign oc_tag_rd = oc_tag_m[arr_idx];
  assign ic_dat_rd = ic_dat_m[{arr_idx[7:0], arr_word}];
  assign oc_dat_rd = oc_dat_m[{arr_idx, arr_word}];

  always @(posedge clk) begin
    if (ic_tag_we) ic_tag_m[arr_idx[7:0]] <= tag_wd[19:0];
    if (oc_tag_we) oc_tag_m[arr_idx] <= tag_wd;
    if (ic_dat_we) ic_dat_m[{arr_idx[7:0], arr_word}] <= dat_wd;
    if (oc_dat_we) oc_dat_m[{arr_idx, arr_word}] <= dat_wd;
  end

  // Writeback responder
  int          ack_delay = 0;
  int          wb_cnt = 0;
  int          wb_seen = 0;
  logic [8:0]  wb_last_idx;
  logic [20:0] ent_at_ack;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_ack <= 1'b0;
      wb_cnt <= 0;
    end else if (wb_req && !wb_ack) begin
      if (wb_cnt >= ack_delay) begin
        wb_ack      <= 1'b1;
        wb_cnt      <= 0;
        wb_seen     <= wb_seen + 1;
        wb_last_idx <= wb_idx;
        ent_at_ack  <= oc_tag_m[wb_idx];
      end else begin
        wb_cnt <= wb_cnt + 1;
      end
    end else begin
      wb_ack <= 1'b0;
    end
  end

  cache_array_port u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ready(acc_ready), .acc_done(acc_done), .acc_rdata(acc_rdata),
    .arr_idx(arr_idx), .arr_word(arr_word),
    .ic_tag_rd(ic_tag_rd), .oc_tag_rd(oc_tag_rd),
    .ic_dat_rd(ic_dat_rd), .oc_dat_rd(oc_dat_rd),
    .tag_wd(tag_wd), .dat_wd(dat_wd),
    .ic_tag_we(ic_tag_we), .oc_tag_we(oc_tag_we),
    .ic_dat_we(ic_dat_we), .oc_dat_we(oc_dat_we),
    .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [7:0] win, input int idx,
                                          input int word, input bit asc);
    logic [31:0] a;
    a = {win, 24'h0} | (32'(idx) << 5) | (32'(word) << 2);
    if (asc) a[3] = 1'b1;
    return a;
  endfunction

  function automatic logic [31:0] mk_tagw(input logic [18:0] tag, input bit d, input bit v);
    return {3'b0, tag, 8'b0, d, v};
  endfunction

  task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_addr = a; acc_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    rd = 32'hDEAD_DEAD;
    for (int i = 0; i < 50; i++) begin
      if (acc_done) begin
        rd = acc_rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R11 reset ready", {31'b0, acc_ready}, 32'd1);
    check("R11 reset done", {31'b0, acc_done}, 32'd0);
    check("R11 reset wb_req", {31'b0, wb_req}, 32'd0);
  endtask

  task automatic t_tag_reads;
    logic [31:0] rd;
    oc_tag_m[9'h1A3] = {1'b1, 1'b1, 19'h5A5A5};
    access(0, 2'd2, mk_addr(8'hF4, 'h1A3, 0, 0), 0, rd);
    check("R4 operand tag read", rd, mk_tagw(19'h5A5A5, 1, 1));
    ic_tag_m[8'h7E] = {1'b1, 19'h31F0E};
    access(0, 2'd2, mk_addr(8'hF0, 'h7E, 0, 0) | 32'h2000, 0, rd);
    check("R3 R4 instruction tag read, bit 13 ignored", rd, mk_tagw(19'h31F0E, 0, 1));
  endtask

  task automatic t_size;
    logic [31:0] rd;
    int seen0;
    access(0, 2'd0, mk_addr(8'hF4, 'h1A3, 0, 0), 0, rd);
    check("R2 byte read returns 0", rd, 32'd0);
    seen0 = wb_seen;
    access(1, 2'd1, mk_addr(8'hF4, 'h1A3, 0, 0), mk_tagw(19'h00001, 0, 1), rd);
    check("R2 half write leaves entry", {11'b0, oc_tag_m[9'h1A3]}, {11'b0, 1'b1, 1'b1, 19'h5A5A5});
    check("R2 half write raises no writeback", 32'(wb_seen - seen0), 32'd0);
  endtask

  task automatic t_window;
    logic [31:0] rd;
    oc_dat_m[{9'h0AA, 3'd2}] = 32'h1234_5678;
    access(0, 2'd2, mk_addr(8'hF2, 'h0AA, 2, 0), 0, rd);
    check("R1 unmapped window read 0", rd, 32'd0);
    access(1, 2'd2, mk_addr(8'hF2, 'h0AA, 2, 0), 32'hFFFF_FFFF, rd);
    check("R1 unmapped window write ignored", oc_dat_m[{9'h0AA, 3'd2}], 32'h1234_5678);
    access(0, 2'd2, mk_addr(8'hF5, 'h0AA, 2, 0), 0, rd);
    check("R1 operand data window read", rd, 32'h1234_5678);
  endtask

  task automatic t_data;
    logic [31:0] rd;
    access(1, 2'd2, mk_addr(8'hF5, 'h155, 5, 0), 32'hCAFE_F00D, rd);
    check("R10 operand data write", oc_dat_m[{9'h155, 3'd5}], 32'hCAFE_F00D);
    check("R11 write returns 0", rd, 32'd0);
    access(0, 2'd2, mk_addr(8'hF5, 'h155, 5, 0), 0, rd);
    check("R10 operand data readback", rd, 32'hCAFE_F00D);
    ic_dat_m[{8'h33, 3'd7}] = 32'h0BAD_BEEF;
    access(0, 2'd2, mk_addr(8'hF1, 'h33, 7, 0), 0, rd);
    check("R3 R10 instruction data read word 7", rd, 32'h0BAD_BEEF);
  endtask

  task automatic t_oc_direct;
    logic [31:0] rd;
    int seen0;
    oc_tag_m[9'h010] = {1'b0, 1'b1, 19'h11111};
    seen0 = wb_seen;
    access(1, 2'd2, mk_addr(8'hF4, 'h010, 0, 0), mk_tagw(19'h22222, 1, 1), rd);
    check("R5 direct write clean line", {11'b0, oc_tag_m[9'h010]}, {11'b0, 1'b1, 1'b1, 19'h22222});
    check("R5 clean line no writeback", 32'(wb_seen - seen0), 32'd0);
    oc_tag_m[9'h011] = {1'b1, 1'b1, 19'h33333};
    ack_delay = 3;
    access(1, 2'd2, mk_addr(8'hF4, 'h011, 0, 0), mk_tagw(19'h44444, 0, 1), rd);
    ack_delay = 0;
    check("R5 dirty line writeback count", 32'(wb_seen - seen0), 32'd1);
    check("R5 writeback index", {23'b0, wb_last_idx}, 32'h011);
    check("R11 old entry kept until ack", {11'b0, ent_at_ack}, {11'b0, 1'b1, 1'b1, 19'h33333});
    check("R5 dirty line new entry", {11'b0, oc_tag_m[9'h011]}, {11'b0, 1'b0, 1'b1, 19'h44444});
  endtask

  task automatic t_ic_direct;
    logic [31:0] rd;
    ic_tag_m[8'h40] = 20'h0;
    access(1, 2'd2, mk_addr(8'hF0, 'h40, 0, 0), mk_tagw(19'h12345, 1, 1), rd);
    check("R6 instruction direct write", {12'b0, ic_tag_m[8'h40]}, {12'b0, 1'b1, 19'h12345});
  endtask

  task automatic t_assoc_miss;
    logic [31:0] rd;
    int seen0;
    seen0 = wb_seen;
    oc_tag_m[9'h020] = {1'b1, 1'b1, 19'h0AAAA};
    access(1, 2'd2, mk_addr(8'hF4, 'h020, 0, 1), mk_tagw(19'h0BBBB, 0, 1), rd);
    check("R7 operand tag mismatch ignored", {11'b0, oc_tag_m[9'h020]}, {11'b0, 1'b1, 1'b1, 19'h0AAAA});
    oc_tag_m[9'h021] = {1'b1, 1'b0, 19'h0CCCC};
    access(1, 2'd2, mk_addr(8'hF4, 'h021, 0, 1), mk_tagw(19'h0CCCC, 1, 1), rd);
    check("R7 invalid line ignored", {11'b0, oc_tag_m[9'h021]}, {11'b0, 1'b1, 1'b0, 19'h0CCCC});
    check("R7 miss raises no writeback", 32'(wb_seen - seen0), 32'd0);
    ic_tag_m[8'h42] = {1'b1, 19'h13579};
    access(1, 2'd2, mk_addr(8'hF0, 'h42, 0, 1), mk_tagw(19'h1357A, 0, 0), rd);
    check("R7 instruction mismatch ignored", {12'b0, ic_tag_m[8'h42]}, {12'b0, 1'b1, 19'h13579});
  endtask

  task automatic t_assoc_hit;
    logic [31:0] rd;
    int seen0;
    seen0 = wb_seen;
    oc_tag_m[9'h022] = {1'b1, 1'b1, 19'h0DDDD};
    access(1, 2'd2, mk_addr(8'hF4, 'h022, 0, 1), mk_tagw(19'h0DDDD, 0, 0), rd);
    check("R8 hit with bits 00 clears line", {11'b0, oc_tag_m[9'h022]}, {11'b0, 1'b0, 1'b0, 19'h0DDDD});
    check("R8 bits 00 no writeback", 32'(wb_seen - seen0), 32'd0);
    oc_tag_m[9'h023] = {1'b1, 1'b1, 19'h0EEEE};
    ack_delay = 1;
    access(1, 2'd2, mk_addr(8'hF4, 'h023, 0, 1), mk_tagw(19'h0EEEE, 0, 1), rd);
    ack_delay = 0;
    check("R8 hit on dirty line writes back", 32'(wb_seen - seen0), 32'd1);
    check("R8 writeback index", {23'b0, wb_last_idx}, 32'h023);
    check("R8 new status, tag kept", {11'b0, oc_tag_m[9'h023]}, {11'b0, 1'b0, 1'b1, 19'h0EEEE});
    ic_tag_m[8'h41] = {1'b1, 19'h2468A};
    access(1, 2'd2, mk_addr(8'hF0, 'h41, 0, 1), mk_tagw(19'h2468A, 1, 0), rd);
    check("R9 instruction hit updates valid only", {12'b0, ic_tag_m[8'h41]}, {12'b0, 1'b0, 19'h2468A});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ic_tag_m[i] = '0;
    for (int i = 0; i < 512; i++) oc_tag_m[i] = '0;
    for (int i = 0; i < 2048; i++) ic_dat_m[i] = '0;
    for (int i = 0; i < 4096; i++) oc_dat_m[i] = '0;
    acc_valid = 0; acc_write = 0; acc_size = 0; acc_addr = 0; acc_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tag_reads();
    t_size();
    t_window();
    t_data();
    t_oc_direct();
    t_ic_direct();
    t_assoc_miss();
    t_assoc_hit();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule